// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block buffers words between two clock domains whose clocks may run at any rates with no relation between them. Words enter on the write port and leave in the same order on the read port. The read data output is registered and changes only on a read clock edge that accepts a read. Five active-low status flags report the fill level: empty, full, half-full, almost-empty and almost-full.

The almost-empty and almost-full thresholds are held in two offset registers in the write domain. A separate loader block fills them through a load strobe. Master reset returns them to parameter defaults. Master reset also captures the flag timing mode, which is either synchronous or asynchronous. Partial reset clears the pointers and the output register but keeps the offsets and the mode. Pointers cross between the domains as Gray code through two-stage synchronizers. The empty flag is computed in the read domain, and the full and half-full flags in the write domain.

Top module: `xclk_fifo_pf`

## Requirements
- R1: After master reset or partial reset, empty_n_o is 0, full_n_o and half_n_o are 1, and rdata_o is all zeros.
- R2: Words are read out in the order they were written. rdata_o takes the next word on the rclk_i edge that accepts a read, and holds it otherwise.
- R3: A write while full_n_o is 0 is dropped without overwriting stored data. A read while empty_n_o is 0 is dropped, and rdata_o keeps its last value.
- R4: full_n_o goes to 0 on the wclk_i edge that stores the DEPTH-th word. empty_n_o returns to 0 once every stored word has been read.
- R5: half_n_o goes to 0 on the wclk_i edge that brings the stored count to DEPTH/2+1, and it stays 1 at DEPTH/2 words.
- R6: aempty_n_o is 0 while the stored count is below the empty offset, and 1 once the count is at least the offset.
- R7: afull_n_o is 0 while the free locations (DEPTH minus count) are at most the full offset, and 1 when more are free.
- R8: In synchronous mode, aempty_n_o changes only on rclk_i and afull_n_o changes only on wclk_i. In asynchronous mode, a write edge can release aempty_n_o and a read edge can release afull_n_o, each right after that edge.
- R9: sync_mode_i is captured only while rst_ni is low: 0 selects asynchronous mode and 1 selects synchronous mode. Later changes of sync_mode_i have no effect.
- R10: Partial reset (prst_ni low) keeps the loaded offsets and the flag mode. Master reset restores the offsets to AE_DEF and AF_DEF (both 2 by default).
- R11: A wclk_i edge with off_ld_i high, outside master reset, loads ae_off_i and af_off_i into the offset registers.
- R12: Data and flags stay correct with wclk_i and rclk_i at unrelated periods. Each pointer crosses domains in Gray code through two register stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low |
| prst_ni | input | 1 | Partial reset, active low |
| sync_mode_i | input | 1 | Flag timing mode captured at master reset (1 = synchronous) |
| off_ld_i | input | 1 | Offset load strobe, write domain |
| ae_off_i | input | AW+1 | Almost-empty offset to load |
| af_off_i | input | AW+1 | Almost-full offset to load |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read enable |
| rdata_o | output | DATA_W | Registered read data |
| empty_n_o | output | 1 | Empty flag, active low |
| full_n_o | output | 1 | Full flag, active low |
| half_n_o | output | 1 | Half-full flag, active low |
| aempty_n_o | output | 1 | Almost-empty flag, active low |
| afull_n_o | output | 1 | Almost-full flag, active low |

## Verification
A short burst written and read back separates correct ordering from pointer or address faults. A fill to full with one extra write, followed by a full drain and one extra read, exposes overflow and underflow leaks as well as wrong full, half-full and empty thresholds. The almost flags are checked one word either side of each offset, and the check is repeated with one clock stopped. A flag that moves while its owning clock is halted marks asynchronous mode, and one that waits marks synchronous mode. Reset-time mode capture is tested by toggling sync_mode_i after reset. Offset retention is tested by using non-default offsets across a partial reset and then across a master reset.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
  typedef enum logic {
    FM_ASYNC = 1'b0,
    FM_SYNC  = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/xfp_ptr_sync.sv
module xfp_ptr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         clr_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge clr_ni)
        if (!clr_ni) stg_q[0] <= '0;
        else         stg_q[0] <= gray_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge clr_ni)
        if (!clr_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_comb begin
    bin_o = stg_q[STAGES-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ stg_q[STAGES-1][i];
  end
endmodule

// File: rtl/xfp_wr_ctl.sv
module xfp_wr_ctl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = AW + 1
) (
  input  logic          wclk_i,
  input  logic          clr_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] rbin_s_i,
  input  logic [CW-1:0] af_off_i,
  output logic [CW-1:0] wbin_o,
  output logic [CW-1:0] wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output logic          full_o,
  output logic          half_o,
  output logic          afull_o
);
  logic [CW-1:0] wbin_q, wgray_q, wbin_nx, cnt_nx;
  logic          full_q, half_q, afull_q;

  assign we_o    = wr_en_i & ~full_q;
  assign wbin_nx = wbin_q + CW'(we_o);
  assign cnt_nx  = wbin_nx - rbin_s_i;

  always_ff @(posedge wclk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      full_q  <= (cnt_nx == CW'(DEPTH));
      half_q  <= (cnt_nx >= CW'(DEPTH / 2 + 1));
      afull_q <= ((CW'(DEPTH) - cnt_nx) <= af_off_i);
    end
  end

  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
  assign waddr_o = wbin_q[AW-1:0];
  assign full_o  = full_q;
  assign half_o  = half_q;
  assign afull_o = afull_q;

  p_wcount_bound_r4: assert property (@(posedge wclk_i) disable iff (!clr_ni)
    (wbin_q - rbin_s_i) <= CW'(DEPTH));
  p_wgray_step_r12: assert property (@(posedge wclk_i) disable iff (!clr_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!clr_ni)
    full_q && wr_en_i |=> wbin_q == $past(wbin_q));
endmodule

// File: rtl/xfp_rd_ctl.sv
module xfp_rd_ctl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = AW + 1
) (
  input  logic          rclk_i,
  input  logic          clr_ni,
  input  logic          rd_en_i,
  input  logic [CW-1:0] wbin_s_i,
  input  logic [CW-1:0] ae_off_i,
  output logic [CW-1:0] rbin_o,
  output logic [CW-1:0] rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          re_o,
  output logic          empty_o,
  output logic          aempty_o
);
  logic [CW-1:0] rbin_q, rgray_q, rbin_nx, cnt_nx;
  logic          empty_q, aempty_q;

  assign re_o    = rd_en_i & ~empty_q;
  assign rbin_nx = rbin_q + CW'(re_o);
  assign cnt_nx  = wbin_s_i - rbin_nx;

  always_ff @(posedge rclk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
    end else begin
      rbin_q   <= rbin_nx;
      rgray_q  <= rbin_nx ^ (rbin_nx >> 1);
      empty_q  <= (cnt_nx == '0);
      aempty_q <= (cnt_nx < ae_off_i);
    end
  end

  assign rbin_o   = rbin_q;
  assign rgray_o  = rgray_q;
  assign raddr_o  = rbin_q[AW-1:0];
  assign empty_o  = empty_q;
  assign aempty_o = aempty_q;

  p_rcount_bound_r4: assert property (@(posedge rclk_i) disable iff (!clr_ni)
    (wbin_s_i - rbin_q) <= CW'(DEPTH));
  p_rgray_step_r12: assert property (@(posedge rclk_i) disable iff (!clr_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  p_no_underflow_r3: assert property (@(posedge rclk_i) disable iff (!clr_ni)
    empty_q && rd_en_i |=> rbin_q == $past(rbin_q));
endmodule

// File: rtl/xfp_mem.sv
module xfp_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              clr_ni,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ram_q [DEPTH];

  always_ff @(posedge wclk_i)
    if (we_i) ram_q[waddr_i] <= wdata_i;

  always_ff @(posedge rclk_i or negedge clr_ni)
    if (!clr_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= ram_q[raddr_i];

  p_rdata_hold_r2: assert property (@(posedge rclk_i) disable iff (!clr_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/xclk_fifo_pf.sv
module xclk_fifo_pf
  import xfp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic              sync_mode_i,
  input  logic              off_ld_i,
  input  logic [CW-1:0]     ae_off_i,
  input  logic [CW-1:0]     af_off_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_n_o,
  output logic              full_n_o,
  output logic              half_n_o,
  output logic              aempty_n_o,
  output logic              afull_n_o
);
  logic          clr_n;
  flag_mode_e    mode_q;
  logic [CW-1:0] ae_q, af_q;
  logic [CW-1:0] wbin, wgray, rbin, rgray, wbin_s, rbin_s, cnt_raw;
  logic [AW-1:0] waddr, raddr;
  logic          we, re, full, half, afull_s, empty, aempty_s;
  logic          aempty_a, afull_a;

  assign clr_n = rst_ni & prst_ni;

  // configuration: only master reset touches it; treated as static by the read side
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) begin
      mode_q <= flag_mode_e'(sync_mode_i);
      ae_q   <= CW'(AE_DEF);
      af_q   <= CW'(AF_DEF);
    end else if (off_ld_i) begin
      ae_q <= ae_off_i;
      af_q <= af_off_i;
    end
  end

  xfp_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
    .wclk_i, .clr_ni(clr_n), .wr_en_i, .rbin_s_i(rbin_s), .af_off_i(af_q),
    .wbin_o(wbin), .wgray_o(wgray), .waddr_o(waddr), .we_o(we),
    .full_o(full), .half_o(half), .afull_o(afull_s)
  );

  xfp_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rd (
    .rclk_i, .clr_ni(clr_n), .rd_en_i, .wbin_s_i(wbin_s), .ae_off_i(ae_q),
    .rbin_o(rbin), .rgray_o(rgray), .raddr_o(raddr), .re_o(re),
    .empty_o(empty), .aempty_o(aempty_s)
  );

  xfp_ptr_sync #(.W(CW), .STAGES(2)) u_w2r (
    .clk_i(rclk_i), .clr_ni(clr_n), .gray_i(wgray), .bin_o(wbin_s)
  );

  xfp_ptr_sync #(.W(CW), .STAGES(2)) u_r2w (
    .clk_i(wclk_i), .clr_ni(clr_n), .gray_i(rgray), .bin_o(rbin_s)
  );

  xfp_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk_i, .we_i(we), .waddr_i(waddr), .wdata_i,
    .rclk_i, .clr_ni(clr_n), .re_i(re), .raddr_i(raddr), .rdata_o
  );

  // asynchronous-mode flags: follow both live pointers, so each edge acts at once
  assign cnt_raw  = wbin - rbin;
  assign aempty_a = (cnt_raw < ae_q);
  assign afull_a  = ((CW'(DEPTH) - cnt_raw) <= af_q);

  assign empty_n_o  = ~empty;
  assign full_n_o   = ~full;
  assign half_n_o   = ~half;
  assign aempty_n_o = ~((mode_q == FM_SYNC) ? aempty_s : aempty_a);
  assign afull_n_o  = ~((mode_q == FM_SYNC) ? afull_s  : afull_a);

  p_mode_fixed_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_q));
  p_cfg_hold_r10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !off_ld_i |=> $stable(ae_q) && $stable(af_q));
endmodule

// File: tb/xclk_fifo_pf_tb_top.sv
`timescale 1ns/1ps
module xclk_fifo_pf_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int CW = 5;

  logic wclk = 0, rclk = 0, w_run = 1, r_run = 1;
  logic rst_ni = 0, prst_ni = 1, sync_mode = 1, off_ld = 0;
  logic [CW-1:0] ae_off = '0, af_off = '0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wdata = '0, rdata;
  logic empty_n, full_n, half_n, aempty_n, afull_n;
  int total = 0, bad = 0;
  bit done = 0;

  initial forever begin #10; if (w_run) wclk = ~wclk; end
  initial forever begin #17; if (r_run) rclk = ~rclk; end

  xclk_fifo_pf dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni, .prst_ni, .sync_mode_i(sync_mode),
    .off_ld_i(off_ld), .ae_off_i(ae_off), .af_off_i(af_off),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .empty_n_o(empty_n), .full_n_o(full_n), .half_n_o(half_n),
    .aempty_n_o(aempty_n), .afull_n_o(afull_n)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic settle_w(); repeat (6) @(negedge wclk); endtask
  task automatic settle_r(); repeat (6) @(negedge rclk); endtask
  task automatic settle();   settle_w(); settle_r(); endtask

  task automatic wr(logic [DW-1:0] d);
    @(negedge wclk); wr_en = 1; wdata = d;
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic rd(output logic [DW-1:0] d);
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0; d = rdata;
  endtask

  task automatic halt_r(); @(negedge rclk); r_run = 0; endtask
  task automatic halt_w(); @(negedge wclk); w_run = 0; endtask

  task automatic master_reset(logic mode);
    sync_mode = mode; rst_ni = 0;
    repeat (4) @(negedge wclk);
    rst_ni = 1;
    settle();
  endtask

  task automatic t_reset();
    master_reset(1);
    check("R1 empty", 32'(empty_n), 0);
    check("R1 full", 32'(full_n), 1);
    check("R1 half", 32'(half_n), 1);
    check("R1 rdata", rdata, 0);
  endtask

  task automatic t_order();
    logic [DW-1:0] d;
    for (int i = 0; i < 5; i++) wr(32'hA000_0000 + 32'(i * 7));
    settle();
    for (int i = 0; i < 5; i++) begin
      rd(d);
      check("R2 R12 order", d, 32'hA000_0000 + 32'(i * 7));
    end
    settle();
    check("R4 empty after drain", 32'(empty_n), 0);
  endtask

  task automatic t_fill();
    logic [DW-1:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      wr(32'h5500 + 32'(i));
      if (i == DEPTH / 2 - 1) check("R5 half at N/2", 32'(half_n), 1);
      if (i == DEPTH / 2)     check("R5 half at N/2+1", 32'(half_n), 0);
      if (i == DEPTH - 2)     check("R4 not full at N-1", 32'(full_n), 1);
    end
    check("R4 full", 32'(full_n), 0);
    wr(32'hDEAD_BEEF);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      rd(d);
      check("R3 R2 overflow dropped", d, 32'h5500 + 32'(i));
    end
    check("R4 empty", 32'(empty_n), 0);
    rd(d);
    check("R3 underflow holds rdata", d, 32'h5500 + 32'(DEPTH - 1));
    settle();
  endtask

  task automatic t_flags_sync();
    logic [DW-1:0] d;
    master_reset(1);
    @(negedge wclk); off_ld = 1; ae_off = 5'd3; af_off = 5'd4;
    @(negedge wclk); off_ld = 0; ae_off = '0; af_off = '0;
    wr(1); wr(2); settle();
    check("R6 R11 aempty below", 32'(aempty_n), 0);
    check("R7 afull idle", 32'(afull_n), 1);
    halt_r(); wr(3); settle_w();
    check("R8 sync aempty waits for rclk", 32'(aempty_n), 0);
    r_run = 1; settle_r();
    check("R6 aempty at offset", 32'(aempty_n), 1);
    for (int i = 0; i < 8; i++) wr(32'(10 + i));
    settle_w();
    check("R7 afull free=5", 32'(afull_n), 1);
    wr(99);
    check("R7 afull free=4", 32'(afull_n), 0);
    halt_w(); rd(d); settle_r();
    check("R8 sync afull waits for wclk", 32'(afull_n), 0);
    w_run = 1; settle_w();
    check("R7 afull released", 32'(afull_n), 1);
  endtask

  task automatic t_partial();
    sync_mode = 0;
    @(negedge wclk); prst_ni = 0;
    repeat (3) @(negedge wclk);
    check("R1 partial empty", 32'(empty_n), 0);
    check("R1 partial full", 32'(full_n), 1);
    check("R1 partial rdata", rdata, 0);
    prst_ni = 1; settle();
    wr(7); wr(8); settle();
    check("R10 offset kept", 32'(aempty_n), 0);
    halt_r(); wr(9); settle_w();
    check("R9 R10 mode kept sync", 32'(aempty_n), 0);
    r_run = 1; settle_r();
    check("R10 aempty at kept offset", 32'(aempty_n), 1);
  endtask

  task automatic t_async();
    logic [DW-1:0] d;
    master_reset(0);
    sync_mode = 1;
    wr(1); settle();
    check("R10 default offset", 32'(aempty_n), 0);
    halt_r(); wr(2);
    check("R8 R9 async aempty on wclk", 32'(aempty_n), 1);
    r_run = 1;
    for (int i = 0; i < 12; i++) wr(32'(20 + i));
    settle();
    check("R7 R10 afull free=2", 32'(afull_n), 0);
    halt_w(); rd(d);
    check("R8 async afull on rclk", 32'(afull_n), 1);
    w_run = 1; settle();
  endtask

  initial begin
    t_reset();
    t_order();
    t_fill();
    t_flags_sync();
    t_partial();
    t_async();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule